// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block captures a word presented on its parallel inputs and then sends it out one bit per clock on a single serial line. A mode input selects between a clocked parallel capture (mode low) and a one-position shift toward the output end (mode high). A hold input freezes the whole register when high, so neither a capture nor a shift happens on that edge.

The parallel bus is ordered so that its top bit feeds the stage farthest from the output and its bit 0 feeds the output stage. After a capture, the least significant bit is therefore already on the output, and the rest follow in rising bit order. During each shift, the stage farthest from the output takes its new value from a fill input. After enough shifts, the fill bits leave the output in the order they were applied. Every action, including the active-high reset, takes effect on the rising clock edge. The register width is a parameter.

Top module: `piso_shifter`

## Requirements
- R1: With `rst` high at a rising edge, every stage clears and `ser_out` is 0 after that edge, whatever the other inputs are.
- R2: With `rst` low, `hold` low and `shift_mode` low at a rising edge, the word on `par_in` is captured, and `ser_out` equals `par_in[0]` after that edge.
- R3: With `rst` low, `hold` low and `shift_mode` high, each rising edge moves the contents one stage toward the output. After k shifts following a capture (k < WIDTH), `ser_out` equals the captured `par_in[k]`. With WIDTH 3 and a captured value of 3'b011, the output reads 1, 1, 0.
- R4: On every shift, `fill_in` enters the stage farthest from the output. The fill bit sampled at shift j following a capture appears on `ser_out` after shift WIDTH+j−1.
- R5: While `hold` is high (and `rst` is low), the register keeps its contents on every edge, whatever `shift_mode`, `par_in` and `fill_in` are. A stream that is paused and then resumed delivers every remaining bit in order, with none lost or repeated.
- R6: Reset takes priority over both capture and shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_mode | input | 1 | 1 = shift toward output, 0 = parallel capture |
| hold | input | 1 | 1 = freeze the register on this edge |
| fill_in | input | 1 | Bit entering the far stage on each shift |
| par_in | input | WIDTH | Parallel word; bit WIDTH-1 feeds the far stage, bit 0 the output stage |
| ser_out | output | 1 | Output stage contents |

## Verification
The bench builds two instances side by side: WIDTH 5 and WIDTH 3. Both share their controls and take the low bits of one common parallel word. The 3-bit instance reaches the short capture-then-three-shifts case, so fill bits start arriving after only three shifts. The 5-bit instance keeps a longer stream in flight, which leaves room to pause it with the hold input at several depths and to overwrite it partway through. A queue-based model of each instance is compared on every cycle, through directed sequences followed by a pseudo-random mix of capture, shift, hold and reset.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_CAPT  = 2'd1,
    ACT_SHIFT = 2'd2,
    ACT_CLEAR = 2'd3
  } piso_act_e;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic      rst,
  input  logic      shift_mode,
  input  logic      hold,
  output piso_act_e act
);
  always_comb begin
    if (rst)             act = ACT_CLEAR;
    else if (hold)       act = ACT_KEEP;
    else if (shift_mode) act = ACT_SHIFT;
    else                 act = ACT_CAPT;
  end
endmodule

// File: rtl/piso_stage.sv
module piso_stage
  import piso_pkg::*;
(
  input  logic      clk,
  input  piso_act_e act,
  input  logic      capt_bit,
  input  logic      prev_bit,
  output logic      q
);
  always_ff @(posedge clk) begin
    case (act)
      ACT_CLEAR: q <= 1'b0;
      ACT_CAPT:  q <= capt_bit;
      ACT_SHIFT: q <= prev_bit;
      default:   q <= q;
    endcase
  end
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_mode,
  input  logic             hold,
  input  logic             fill_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out
);
  localparam int LAST = WIDTH - 1;

  piso_act_e        act;
  logic [WIDTH-1:0] stages;

  piso_ctrl u_ctrl (
    .rst        (rst),
    .shift_mode (shift_mode),
    .hold       (hold),
    .act        (act)
  );

  // stage 0 is farthest from the output; it takes the top parallel bit
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic upstream;
    if (k == 0) begin : g_head
      assign upstream = fill_in;
    end else begin : g_body
      assign upstream = stages[k-1];
    end
    piso_stage u_stage (
      .clk      (clk),
      .act      (act),
      .capt_bit (par_in[LAST-k]),
      .prev_bit (upstream),
      .q        (stages[k])
    );
  end

  assign ser_out = stages[LAST];
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_mode,
  input logic             hold,
  input logic             fill_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stages,
  input logic             ser_out
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ser_out == 1'b0) && (stages == '0));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold && !shift_mode) |=> ser_out == $past(par_in[0]));

  p_shift_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (!hold && shift_mode) |=> ser_out == $past(stages[WIDTH-2]));

  p_fill_enter_r4: assert property (@(posedge clk) disable iff (rst)
    (!hold && shift_mode) |=> stages[0] == $past(fill_in));

  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(stages));

  p_reset_wins_r6: assert property (@(posedge clk)
    (rst && !hold) |=> stages == '0);
endmodule

bind piso_shifter piso_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shift_mode (shift_mode),
  .hold       (hold),
  .fill_in    (fill_in),
  .par_in     (par_in),
  .stages     (stages),
  .ser_out    (ser_out)
);

// File: tb/piso_shifter_test.sv
module piso_shifter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shift_mode = 1'b0;
  logic       hold = 1'b0;
  logic       fill_in = 1'b0;
  logic [4:0] par = 5'd0;
  logic       out5, out3;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  bit    q5[$];
  bit    q3[$];

  always #4 clk = ~clk;

  piso_shifter #(.WIDTH(5)) uut (
    .clk(clk), .rst(rst), .shift_mode(shift_mode), .hold(hold),
    .fill_in(fill_in), .par_in(par), .ser_out(out5));

  piso_shifter #(.WIDTH(3)) uut3 (
    .clk(clk), .rst(rst), .shift_mode(shift_mode), .hold(hold),
    .fill_in(fill_in), .par_in(par[2:0]), .ser_out(out3));

  task automatic model_edge(ref bit q[$], input int w);
    if (rst) begin
      q = {};
      for (int i = 0; i < w; i++) q.push_back(1'b0);
    end else if (!hold) begin
      if (!shift_mode) begin
        q = {};
        for (int i = 0; i < w; i++) q.push_back(par[i]);
      end else begin
        void'(q.pop_front());
        q.push_back(fill_in);
      end
    end
  endtask

  task automatic compare(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: ser_out=%b expected=%b at %0t", cur_req, tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge(q5, 5);
    model_edge(q3, 3);
    @(negedge clk);
    compare("w5", out5, q5[0]);
    compare("w3", out3, q3[0]);
  endtask

  task automatic drive(input logic r, input logic m, input logic h,
                       input logic f, input logic [4:0] p);
    rst = r; shift_mode = m; hold = h; fill_in = f; par = p;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    // R1: reset clears, with capture data present
    cur_req = "R1";
    drive(1, 0, 0, 1, 5'b11111);
    drive(1, 1, 0, 1, 5'b11111);
    // R2: capture; 3-bit sees 011
    cur_req = "R2";
    drive(0, 0, 0, 0, 5'b10011);
    // R3: LSB-first: w3 gives 1,1,0 ; w5 gives 1,1,0,0,1
    cur_req = "R3";
    drive(0, 1, 0, 1, 5'b00000);
    drive(0, 1, 0, 0, 5'b00000);
    drive(0, 1, 0, 1, 5'b00000);
    drive(0, 1, 0, 1, 5'b00000);
    // R4: fill bits reach the output after the word has drained
    cur_req = "R4";
    for (int i = 0; i < 6; i++) drive(0, 1, 0, i[0], 5'b00000);
    // R5: pause mid-stream, with shift and with capture requested
    cur_req = "R2";
    drive(0, 0, 0, 0, 5'b01101);
    cur_req = "R3";
    drive(0, 1, 0, 1, 5'b00000);
    cur_req = "R5";
    drive(0, 1, 1, 1, 5'b11111);
    drive(0, 0, 1, 0, 5'b00000);
    drive(0, 0, 1, 1, 5'b10101);
    cur_req = "R3";
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 5'b00000);
    // R6: reset beats capture and shift
    cur_req = "R2";
    drive(0, 0, 0, 0, 5'b11111);
    cur_req = "R6";
    drive(1, 0, 0, 1, 5'b11111);
    drive(1, 1, 0, 1, 5'b11111);
    // mixed traffic
    cur_req = "mix R3 R5";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      drive(r < 3, r >= 30, (r % 5) == 0, $urandom_range(0, 1),
            5'($urandom_range(0, 31)));
    end
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule